// File: doc/BRIEF.md
# Condition-Code Predicated Execution Unit

This block keeps the four status flags of a 32-bit core (negative, zero, carry, overflow) and decides, for every instruction that reaches it, whether that instruction is allowed to take effect. The decision uses a 4-bit condition field taken from the most significant bits of the instruction word, evaluated against the stored flags. An instruction whose condition fails is squashed: it writes no register and leaves the flags untouched. A short forward skip can then be expressed as a predicated instruction instead of a branch.

Flag-setting arithmetic and logical instructions load the flags from the ALU result once they have executed. Compare instructions always load the flags and never write a result register. The ALU and the rest of instruction decode sit outside this block. The unit only sees the instruction word, the ALU flags, a flag-update request and a compare marker.

Top module: `cc_predicate_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, the stored flags clear to 0. flags_q packs them as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0, and alu_flags uses the same packing.
- R2: The condition field is instr_word[31:28]. exec_en is combinational in the same cycle and depends on that field and the currently stored flags.
- R3: Condition codes 0 to 13 execute when, in order: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0, 8 C=1 and Z=0, 9 C=0 or Z=1, 10 N=V, 11 N!=V, 12 Z=0 and N=V, 13 Z=1 or N!=V.
- R4: Codes 14 and 15 execute for every flag value.
- R5: An executing instruction with set_flags high loads alu_flags into flags_q on the next clock edge. The instruction after it is evaluated against the new flags.
- R6: An executing instruction with set_flags and cmp_only both low leaves flags_q unchanged.
- R7: An executing instruction with cmp_only high loads alu_flags into flags_q on the next edge, whatever set_flags is, and keeps wb_en low.
- R8: A squashed instruction (exec_en low) drives wb_en low and leaves flags_q unchanged, even with set_flags or cmp_only high.
- R9: wb_en is high exactly when exec_en is high and cmp_only is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | DATA_W | Instruction currently being committed |
| alu_flags | input | 4 | N/Z/C/V produced by the ALU for this instruction |
| set_flags | input | 1 | Instruction requests a flag update |
| cmp_only | input | 1 | Instruction is a compare: flags only, no result |
| exec_en | output | 1 | Condition holds; instruction may commit |
| wb_en | output | 1 | Register writeback permitted |
| flags_q | output | 4 | Stored N/Z/C/V flags |

## Verification
The bench builds the unit with the default DATA_W of 32, so the condition field sits in bits 31 down to 28, and the bench fills the low bits with varying junk to show they are ignored. At that width it loads each of the sixteen flag values through an always-execute flag-setting instruction and walks all sixteen condition codes against each one. Directed sequences then check back-to-back flag updates, compares, plain instructions and squashed instructions that carry update requests.

// File: rtl/cc_predicate_unit.sv
module cc_predicate_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] instr_word,
  input  logic [3:0]        alu_flags,
  input  logic              set_flags,
  input  logic              cmp_only,
  output logic              exec_en,
  output logic              wb_en,
  output logic [3:0]        flags_q
);

  localparam int COND_W = 4;
  localparam int COND_LSB = DATA_W - COND_W;

  logic [COND_W-1:0] cond;
  logic n, z, c, v;
  logic pass;
  logic load_flags;

  assign cond = instr_word[DATA_W-1:COND_LSB];
  assign {n, z, c, v} = flags_q;

  always_comb begin
    case (cond)
      4'd0:    pass = z;
      4'd1:    pass = !z;
      4'd2:    pass = c;
      4'd3:    pass = !c;
      4'd4:    pass = n;
      4'd5:    pass = !n;
      4'd6:    pass = v;
      4'd7:    pass = !v;
      4'd8:    pass = c && !z;
      4'd9:    pass = !c || z;
      4'd10:   pass = (n == v);
      4'd11:   pass = (n != v);
      4'd12:   pass = !z && (n == v);
      4'd13:   pass = z || (n != v);
      default: pass = 1'b1;
    endcase
  end

  assign exec_en    = pass;
  assign wb_en      = pass && !cmp_only;
  assign load_flags = pass && (set_flags || cmp_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_q <= '0;
    else if (load_flags) flags_q <= alu_flags;
  end

  p_always_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond >= 4'd14) |-> exec_en);

  p_flags_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && set_flags) |=> (flags_q == $past(alu_flags)));

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !set_flags && !cmp_only) |=> $stable(flags_q));

  p_cmp_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_only |-> !wb_en);

  p_cmp_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && cmp_only) |=> (flags_q == $past(alu_flags)));

  p_squash_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(flags_q));

  p_wb_follows_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (exec_en && !cmp_only));

  always_ff @(posedge clk) begin
    if (!rst_n) p_reset_clear_r1: assert (flags_q == 4'd0);
  end

endmodule

// File: tb/cc_predicate_unit_bench.sv
module cc_predicate_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_word = '0;
  logic [3:0]  alu_flags = '0;
  logic        set_flags = 1'b0;
  logic        cmp_only = 1'b0;
  logic        exec_en, wb_en;
  logic [3:0]  flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cc_predicate_unit #(.DATA_W(32)) u_cc_predicate_unit (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .alu_flags(alu_flags),
    .set_flags(set_flags), .cmp_only(cmp_only), .exec_en(exec_en),
    .wb_en(wb_en), .flags_q(flags_q)
  );

  function automatic bit model_pass(input logic [3:0] code, input logic [3:0] f);
    bit fn, fz, fc, fv;
    fn = f[3]; fz = f[2]; fc = f[1]; fv = f[0];
    case (code)
      0: return fz;
      1: return !fz;
      2: return fc;
      3: return !fc;
      4: return fn;
      5: return !fn;
      6: return fv;
      7: return !fv;
      8: return fc & !fz;
      9: return !fc | fz;
      10: return fn ~^ fv;
      11: return fn ^ fv;
      12: return !fz & (fn ~^ fv);
      13: return fz | (fn ^ fv);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] code, input logic [27:0] low,
                       input logic [3:0] af, input logic sf, input logic cm);
    @(negedge clk);
    instr_word = {code, low};
    alu_flags = af;
    set_flags = sf;
    cmp_only = cm;
    #1;
  endtask

  task automatic idle();
    drive(4'hE, 28'h0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic load_flags(input logic [3:0] f);
    drive(4'hE, 28'h0, f, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(4'hE, 28'h0, 4'hF, 1'b1, 1'b0);
    chk("R1 flags during reset", flags_q, 0);
    idle();
    rst_n = 1'b1;
    idle();
    chk("R1 flags after reset", flags_q, 0);
  endtask

  task automatic t_sweep();
    for (int f = 0; f < 16; f++) begin
      load_flags(f[3:0]);
      chk("R5 flag load for sweep", flags_q, f);
      for (int code = 0; code < 16; code++) begin
        drive(code[3:0], 28'h0ABCDEF ^ (28'(f) << 4), 4'h0, 1'b0, 1'b0);
        if (code >= 14) chk("R4 always code", exec_en, 1);
        else            chk("R3 condition table", exec_en, model_pass(code[3:0], f[3:0]));
        chk("R2 field from top bits", exec_en, model_pass(code[3:0], f[3:0]));
      end
    end
  endtask

  task automatic t_update();
    load_flags(4'h0);
    drive(4'hE, 28'h1, 4'b0100, 1'b1, 1'b0);
    drive(4'd0, 28'h2, 4'b1000, 1'b1, 1'b0);
    chk("R5 next instr sees new Z", exec_en, 1);
    chk("R5 flags loaded", flags_q, 4'b0100);
    drive(4'd4, 28'h3, 4'h0, 1'b0, 1'b0);
    chk("R5 back-to-back load", flags_q, 4'b1000);
    chk("R5 MI uses new N", exec_en, 1);
  endtask

  task automatic t_hold();
    load_flags(4'b0011);
    drive(4'hE, 28'h5, 4'b1100, 1'b0, 1'b0);
    chk("R9 plain wb", wb_en, 1);
    idle();
    chk("R6 flags kept", flags_q, 4'b0011);
  endtask

  task automatic t_compare();
    load_flags(4'b0000);
    drive(4'hE, 28'h7, 4'b0110, 1'b0, 1'b1);
    chk("R7 cmp executes", exec_en, 1);
    chk("R7 cmp no wb", wb_en, 0);
    idle();
    chk("R7 cmp loads flags", flags_q, 4'b0110);
    drive(4'd1, 28'h7, 4'b0001, 1'b1, 1'b1);
    chk("R9 squashed cmp wb", wb_en, 0);
    idle();
    chk("R8 squashed cmp keeps flags", flags_q, 4'b0110);
  endtask

  task automatic t_squash();
    load_flags(4'b0000);
    drive(4'd0, 28'hFFFFFFF, 4'b1111, 1'b1, 1'b0);
    chk("R8 squashed exec", exec_en, 0);
    chk("R8 squashed wb", wb_en, 0);
    idle();
    chk("R8 squashed flags", flags_q, 0);
    drive(4'd1, 28'h0, 4'b1111, 1'b1, 1'b0);
    chk("R9 wb when exec", wb_en, 1);
    idle();
    chk("R5 executed update", flags_q, 4'b1111);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_update();
    t_hold();
    t_compare();
    t_squash();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule